// File: doc/BRIEF.md
# Programmable Product-Term Logic Block

This block is the AND-OR core of one logic cluster in a small programmable-logic fabric. It receives 36 routed signals and forms two literals from each: the signal itself and its inverse. A programmable AND plane builds a pool of 86 product terms from those 72 literals. A steering matrix then ORs any subset of the pool into each of 16 sum outputs, one for each downstream macrocell. Each output may take anywhere from none to sixteen terms. A single term can drive several outputs at once, so logic that several outputs have in common is built only once.

The configuration is one long word. It is shifted in serially, one bit per clock, while the load strobe is high, and stays static afterwards. The data path from the routed inputs to the sum outputs is purely combinational. Only the configuration storage and two small control flags are clocked. At the end of a load the block checks every output row of the steering matrix. A row that asks for more terms than the per-output limit is rejected: an error flag is raised and the outputs stay quiet.

Top module: `pt_logic_block`

## Requirements
- R1: Input `data_in[i]` feeds literal column 2i in true form and column 2i+1 in complement form. A product term is the AND of every literal column connected to it. An enabled term with no literal connected evaluates to 1.
- R2: A product term whose enable bit is 0 evaluates to 0, whatever its literal connections are.
- R3: Each `sum_out[o]` is the OR of the product terms steered to it. An output with no term steered to it is 0.
- R4: A steering row with exactly 16 bits set is accepted, and its output is the OR of all 16 of those terms.
- R5: One product term steered to several outputs drives each of them at the same time.
- R6: The configuration word has W = 86*72 + 86 + 16*86 bits. It is loaded most significant bit first, one bit on each rising clock edge while `cfg_en` is high. Its fields, counted from bit 0, are:
  - the literal connection for term t and column j at bit t*72+j;
  - the enable for term t at bit 6192+t;
  - the steering bit that routes term t to output o at bit 6278+o*86+t.
- R7: From the first rising edge that samples `cfg_en` high, `sum_out` is held at 0. The outputs become live after the first rising edge that samples `cfg_en` low.
- R8: If any steering row has more than 16 bits set when a load ends, `config_error` goes high and `sum_out` stays 0. A later load clears `config_error` again as soon as an edge samples `cfg_en` high.
- R9: While the block is live, `sum_out` follows changes on `data_in` with no clock edge in between.
- R10: After reset, `sum_out` is 0, `config_error` is 0 and the whole configuration word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Configuration load strobe |
| cfg_din | input | 1 | Serial configuration bit, MSB first |
| data_in | input | 36 | Routed input signals |
| sum_out | output | 16 | Sum-of-products outputs |
| config_error | output | 1 | Last load had an over-full steering row |

## Verification
The bench loads four different configurations and compares the outputs against a behavioural model every cycle.

- A mixed configuration is driven with varied 36-bit patterns. It separates true from complement literal columns, constant-1 terms from disabled terms, and shared terms from private ones.
- A configuration with sixteen single-literal terms on one output is driven with all-zero and walking-one inputs. This shows that every one of the sixteen steered terms reaches the OR.
- An over-full row shows that the load is rejected, and a clean reload shows that the error clears.
- A change on `data_in` between clock edges shows that the path to the outputs has no register in it.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned PT_INPUTS   = 36;
  localparam int unsigned PT_TERMS    = 86;
  localparam int unsigned PT_SUMS     = 16;
  localparam int unsigned PT_MAX_FAN  = 16;
endpackage

// File: rtl/pt_cfg_chain.sv
module pt_cfg_chain #(
  parameter int unsigned TERMS = 86,
  parameter int unsigned SUMS  = 16,
  parameter int unsigned LITS  = 72,
  parameter int unsigned LIMIT = 16,
  localparam int unsigned AND_W = TERMS * LITS,
  localparam int unsigned EN_W  = TERMS,
  localparam int unsigned STR_W = SUMS * TERMS,
  localparam int unsigned CFG_W = AND_W + EN_W + STR_W,
  localparam int unsigned CNT_W = $clog2(TERMS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_din,
  output logic [AND_W-1:0]  and_mask,
  output logic [EN_W-1:0]   term_en,
  output logic [STR_W-1:0]  steer,
  output logic              live,
  output logic              cfg_error
);
  logic [CFG_W-1:0] chain_q;
  logic             loading_q;
  logic [SUMS-1:0]  row_over;
  logic             any_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q   <= '0;
      loading_q <= 1'b0;
      live      <= 1'b0;
      cfg_error <= 1'b0;
    end else begin
      loading_q <= cfg_en;
      if (cfg_en) begin
        chain_q   <= {chain_q[CFG_W-2:0], cfg_din};
        live      <= 1'b0;
        cfg_error <= 1'b0;
      end else if (loading_q) begin
        live      <= ~any_over;
        cfg_error <= any_over;
      end
    end
  end

  assign and_mask = chain_q[AND_W-1:0];
  assign term_en  = chain_q[AND_W +: EN_W];
  assign steer    = chain_q[AND_W+EN_W +: STR_W];

  for (genvar r = 0; r < SUMS; r++) begin : g_row
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int b = 0; b < TERMS; b++)
        cnt = cnt + CNT_W'(steer[r*TERMS + b]);
    end
    assign row_over[r] = (cnt > CNT_W'(LIMIT));
  end
  assign any_over = |row_over;

  // R6
  cfg_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_en) |-> $stable(chain_q));
  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> !cfg_error);
  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !live);
endmodule

// File: rtl/pt_and_plane.sv
module pt_and_plane #(
  parameter int unsigned TERMS = 86,
  parameter int unsigned LITS  = 72
) (
  input  logic [LITS-1:0]        lits,
  input  logic [TERMS*LITS-1:0]  and_mask,
  input  logic [TERMS-1:0]       term_en,
  output logic [TERMS-1:0]       terms
);
  for (genvar t = 0; t < TERMS; t++) begin : g_term
    logic [LITS-1:0] row;
    assign row      = and_mask[t*LITS +: LITS];
    assign terms[t] = term_en[t] & (&(lits | ~row));
  end
endmodule

// File: rtl/pt_allocator.sv
module pt_allocator #(
  parameter int unsigned TERMS = 86,
  parameter int unsigned SUMS  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TERMS-1:0]        terms,
  input  logic [SUMS*TERMS-1:0]   steer,
  output logic [SUMS-1:0]         sums
);
  for (genvar o = 0; o < SUMS; o++) begin : g_sum
    logic [TERMS-1:0] row;
    assign row     = steer[o*TERMS +: TERMS];
    assign sums[o] = |(terms & row);

    // R3
    empty_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row == '0) |-> !sums[o]);
  end
endmodule

// File: rtl/pt_logic_block.sv
module pt_logic_block
  import pt_pkg::*;
#(
  parameter int unsigned N_IN    = PT_INPUTS,
  parameter int unsigned N_TERM  = PT_TERMS,
  parameter int unsigned N_SUM   = PT_SUMS,
  parameter int unsigned MAX_FAN = PT_MAX_FAN,
  localparam int unsigned N_LIT  = 2 * N_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_din,
  input  logic [N_IN-1:0]   data_in,
  output logic [N_SUM-1:0]  sum_out,
  output logic              config_error
);
  logic [N_LIT-1:0]         lits;
  logic [N_TERM*N_LIT-1:0]  and_mask;
  logic [N_TERM-1:0]        term_en;
  logic [N_SUM*N_TERM-1:0]  steer;
  logic [N_TERM-1:0]        terms;
  logic [N_SUM-1:0]         sums;
  logic                     live;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = data_in[i];
    assign lits[2*i+1] = ~data_in[i];
  end

  pt_cfg_chain #(
    .TERMS(N_TERM), .SUMS(N_SUM), .LITS(N_LIT), .LIMIT(MAX_FAN)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .and_mask(and_mask), .term_en(term_en), .steer(steer),
    .live(live), .cfg_error(config_error)
  );

  pt_and_plane #(.TERMS(N_TERM), .LITS(N_LIT)) u_and (
    .lits(lits), .and_mask(and_mask), .term_en(term_en), .terms(terms)
  );

  pt_allocator #(.TERMS(N_TERM), .SUMS(N_SUM)) u_alloc (
    .clk(clk), .rst_n(rst_n), .terms(terms), .steer(steer), .sums(sums)
  );

  assign sum_out = live ? sums : '0;

  // R7
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (sum_out == '0));
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> (sum_out == '0));
endmodule

// File: tb/pt_logic_block_tb.sv
module pt_logic_block_tb_top;
  import pt_pkg::*;
  localparam int NI = PT_INPUTS, NT = PT_TERMS, NS = PT_SUMS;
  localparam int L  = 2 * NI;
  localparam int EB = NT * L;
  localparam int SB = EB + NT;
  localparam int W  = SB + NS * NT;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_din = 0;
  logic [NI-1:0] data_in = '0;
  logic [NS-1:0] sum_out;
  logic config_error;

  always #4 clk = ~clk;

  pt_logic_block dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .data_in(data_in), .sum_out(sum_out), .config_error(config_error)
  );

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R10 reset";
  logic [W-1:0] img;
  logic [W-1:0] m_chain;
  logic m_live, m_err, m_loading;

  function automatic logic [NS-1:0] evaluate(input logic [W-1:0] c, input logic [NI-1:0] d);
    logic [NT-1:0] tv;
    logic [NS-1:0] s;
    for (int t = 0; t < NT; t++) begin
      tv[t] = c[EB + t];
      for (int i = 0; i < NI; i++) begin
        if (c[t*L + 2*i] && !d[i]) tv[t] = 1'b0;
        if (c[t*L + 2*i + 1] && d[i]) tv[t] = 1'b0;
      end
    end
    s = '0;
    for (int o = 0; o < NS; o++)
      for (int t = 0; t < NT; t++)
        if (c[SB + o*NT + t] && tv[t]) s[o] = 1'b1;
    return s;
  endfunction

  function automatic logic overfull(input logic [W-1:0] c);
    for (int o = 0; o < NS; o++) begin
      int n = 0;
      for (int t = 0; t < NT; t++) n += int'(c[SB + o*NT + t]);
      if (n > PT_MAX_FAN) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_chain = '0; m_live = 0; m_err = 0; m_loading = 0;
    end else begin
      if (cfg_en) begin
        m_chain = {m_chain[W-2:0], cfg_din};
        m_live = 0; m_err = 0;
      end else if (m_loading) begin
        m_err = overfull(m_chain);
        m_live = !m_err;
      end
      m_loading = cfg_en;
    end
  end

  task automatic compare(input string tag);
    logic [NS-1:0] exp_s;
    exp_s = m_live ? evaluate(m_chain, data_in) : '0;
    checks++;
    if (sum_out !== exp_s) begin
      fails++;
      $display("FAIL %s sum_out actual=%h expected=%h", tag, sum_out, exp_s);
    end
    checks++;
    if (config_error !== m_err) begin
      fails++;
      $display("FAIL %s config_error actual=%b expected=%b", tag, config_error, m_err);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) compare(phase);
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic lit(input int t, input int i, input int comp);
    img[t*L + 2*i + comp] = 1'b1;
  endtask
  task automatic en(input int t);
    img[EB + t] = 1'b1;
  endtask
  task automatic route(input int o, input int t);
    img[SB + o*NT + t] = 1'b1;
  endtask

  task automatic load();
    for (int b = W - 1; b >= 0; b--) begin
      @(negedge clk); #1;
      cfg_en = 1; cfg_din = img[b];
    end
    @(negedge clk); #1;
    cfg_en = 0; cfg_din = 0;
    @(negedge clk); #1;
  endtask

  task automatic apply(input logic [NI-1:0] v);
    data_in = v;
    @(negedge clk); #1;
  endtask

  task automatic direct(input string tag, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp_v);
    end
  endtask

  task automatic config_a();
    img = '0;
    lit(0, 0, 0); lit(0, 1, 1); en(0);
    en(1);
    lit(2, 5, 0); en(2);
    img[EB + 2] = 1'b0;
    lit(3, 35, 0); lit(3, 34, 0); en(3);
    route(0, 0); route(1, 1); route(2, 2);
    route(3, 0); route(3, 3); route(5, 0);
  endtask

  initial begin
    data_in = 36'h5A5A5A5A5;
    repeat (3) @(negedge clk);
    direct("R10 reset sum_out", |sum_out, 1'b0);
    direct("R10 reset error", config_error, 1'b0);
    #1 rst_n = 1;
    @(negedge clk); #1;
    direct("R10 after reset quiet", |sum_out, 1'b0);

    phase = "R6/R7 load A";
    config_a();
    load();
    phase = "R1/R2/R3/R5 config A";
    apply(36'h0_0000_0001);
    direct("R1 true and complement term", sum_out[0], 1'b1);
    direct("R5 shared term on output 5", sum_out[5], 1'b1);
    direct("R1 const-one term", sum_out[1], 1'b1);
    direct("R2 disabled term", sum_out[2], 1'b0);
    direct("R3 empty output", sum_out[4], 1'b0);
    apply(36'h0_0000_0003);
    direct("R1 complement literal blocks", sum_out[0], 1'b0);
    apply(36'hC_0000_0020);
    direct("R3 OR of second term", sum_out[3], 1'b1);
    direct("R2 disabled despite literal", sum_out[2], 1'b0);
    apply(36'hF_FFFF_FFFF);
    apply(36'h0_0000_0000);
    apply(36'h9_1234_5679);

    phase = "R9 combinational";
    data_in = 36'h0_0000_0001;
    #1 direct("R9 output follows mid-cycle rise", sum_out[0], 1'b1);
    data_in = 36'h0_0000_0002;
    #1 direct("R9 output follows mid-cycle fall", sum_out[0], 1'b0);
    @(negedge clk); #1;

    phase = "R6/R7 load B";
    img = '0;
    for (int k = 0; k < 16; k++) begin
      lit(10 + k, k, 0); en(10 + k); route(7, 10 + k);
    end
    route(8, 10);
    load();
    phase = "R4/R5 config B";
    apply('0);
    direct("R4 all zero gives 0", sum_out[7], 1'b0);
    for (int k = 0; k < 16; k++) begin
      apply(36'(1) << k);
      direct("R4 walking one reaches OR", sum_out[7], 1'b1);
    end
    apply(36'h0_0000_0001);
    direct("R5 shared term output 8", sum_out[8], 1'b1);

    phase = "R8 load over-full";
    img = '0;
    for (int k = 0; k < 17; k++) begin en(k); route(9, k); end
    load();
    phase = "R8 rejected";
    apply(36'hF_FFFF_FFFF);
    direct("R8 error raised", config_error, 1'b1);
    direct("R8 outputs quiet", |sum_out, 1'b0);

    phase = "R8 reload clears";
    config_a();
    load();
    apply(36'h0_0000_0001);
    direct("R8 error cleared", config_error, 1'b0);
    direct("R8 live again", sum_out[0], 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule